// File: doc/BRIEF.md
# Link Width Negotiation Controller

This controller sits at one end of a multi-lane serial link and moves the link between full width and narrower widths without taking it out of its operating state. A width change can start on either side. A local request sends a request message to the partner. The partner must accept or reject it before a response deadline. A request arriving from the partner is answered here with an accept or a reject.

Once a change is agreed, the controller sequences the lanes. On a downsize it commands the lanes being dropped to send their quiesce sequence, and it waits for that sequence to complete before the lanes leave the enable mask. On an upsize it asks for training on the new lanes, and they enter the mask only after training reports completion. The lanes that stay in the mask keep carrying traffic the whole time. Message transport and lane training are reduced to pulse and done handshakes.

Widths use a 3-bit code: code n means 2^n lanes, and the active lanes are always lanes 0 to 2^n-1. With 16 lanes the valid codes are 0 (x1) up to 4 (x16), and codes 5 to 7 are unsupported.

Top module: `lwn_ctrl`

## Requirements
- R1: After reset, lane_en_o has all NUM_LANES bits set and cur_width_o equals log2(NUM_LANES) (4 for 16 lanes). quiesce_o and train_req_o are zero, and tx_req_o, tx_ack_o, tx_nak_o, done_o and fail_o are low.
- R2: A valid local request is sampled on a clock edge while the controller is idle. On the following edge tx_req_o rises for exactly one cycle, with tx_width_o carrying the requested code.
- R3: A local request for an unsupported code (greater than log2(NUM_LANES)) or for the current code sends no message. fail_o pulses on the edge where the request would have been issued, and the width is unchanged.
- R4: A partner request (rx_req_i) for a supported code other than the current one is answered with a one-cycle tx_ack_o. Any other partner request is answered with a one-cycle tx_nak_o and leaves the width unchanged. tx_ack_o and tx_nak_o are never high together.
- R5: After tx_req_o, an answer is accepted on any of the RESP_CYCLES edges that follow the issue edge. If no answer arrives on those edges, fail_o pulses on the last of them and the width is unchanged.
- R6: A partner reject (rx_nak_i) of an outstanding request pulses fail_o and keeps the current width.
- R7: On an agreed downsize, quiesce_o marks exactly the lanes being removed. lane_en_o and cur_width_o hold until quiesce_done_i is sampled. On that edge they take the new width and done_o pulses.
- R8: On an agreed upsize, train_req_o marks exactly the lanes being added. lane_en_o holds until train_done_i is sampled. On that edge it takes the new width and done_o pulses.
- R9: With dsp_i low, a partner request that arrives while a local request is outstanding is rejected with tx_nak_o. The local request stays outstanding.
- R10: With dsp_i high, a partner request that arrives while a local request is outstanding makes the local request withdraw without a fail_o pulse. The partner request is answered as in R4. The withdrawn request is issued again on the first edge after the controller returns to idle.
- R11: Only one negotiation runs at a time. A local request sampled while the controller is busy is held and issued once it returns to idle. A partner request during a lane transition is rejected with tx_nak_o.
- R12: lane_en_o always has lane 0 set, and its number of set bits is a power of two matching cur_width_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dsp_i | input | 1 | High when this end gives way on request collisions |
| loc_req_i | input | 1 | Local width-change request strobe |
| loc_width_i | input | 3 | Requested width code for the local request |
| tx_req_o | output | 1 | Send width request message (one cycle) |
| tx_width_o | output | 3 | Width code carried by the request message |
| tx_ack_o | output | 1 | Send accept answer to the partner |
| tx_nak_o | output | 1 | Send reject answer to the partner |
| rx_req_i | input | 1 | Partner width request received |
| rx_width_i | input | 3 | Width code of the partner request |
| rx_ack_i | input | 1 | Partner accepted the outstanding request |
| rx_nak_i | input | 1 | Partner rejected the outstanding request |
| quiesce_o | output | NUM_LANES | Lanes commanded to send the quiesce sequence and then go idle |
| quiesce_done_i | input | 1 | Quiesce sequence finished on the removed lanes |
| train_req_o | output | NUM_LANES | Lanes asked to train |
| train_done_i | input | 1 | Training finished on the added lanes |
| lane_en_o | output | NUM_LANES | Lanes carrying traffic |
| cur_width_o | output | 3 | Current width code |
| done_o | output | 1 | Width change completed (one cycle) |
| fail_o | output | 1 | Request rejected or timed out (one cycle) |

## Verification
The bench builds the controller with NUM_LANES = 16 and RESP_CYCLES = 8. Sixteen lanes make all five widths and the three unsupported codes reachable. The short deadline lets the bench cover both the timeout and an answer on the last allowed edge within a few cycles. The dsp_i strap is driven both ways, so collisions are exercised from the yielding side and from the side that holds its request.

// File: rtl/lwn_pkg.sv
package lwn_pkg;
  localparam int WCODE_W = 3;
  typedef logic [WCODE_W-1:0] wcode_t;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SHRINK, ST_GROW} lwn_state_e;
endpackage

// File: rtl/lwn_req_hold.sv
module lwn_req_hold
  import lwn_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  wcode_t load_code_i,
  input  logic   consume_i,
  input  logic   requeue_i,
  input  wcode_t requeue_code_i,
  output logic   valid_o,
  output wcode_t code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      code_o  <= load_code_i;
    end else if (requeue_i) begin
      valid_o <= 1'b1;
      code_o  <= requeue_code_i;
    end else if (consume_i) begin
      valid_o <= 1'b0;
    end
  end

  // a request is either taken or pushed back, never both
  assert_take_or_back_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(consume_i && requeue_i));
endmodule

// File: rtl/lwn_resp_timer.sv
module lwn_resp_timer #(
  parameter int RESP_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(RESP_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CNT_W'(RESP_CYCLES - 1));

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < CNT_W'(RESP_CYCLES)));
endmodule

// File: rtl/lwn_lane_map.sv
module lwn_lane_map
  import lwn_pkg::*;
#(
  parameter int NUM_LANES = 16
) (
  input  wcode_t                 cur_code_i,
  input  wcode_t                 tgt_code_i,
  input  logic                   shrink_i,
  input  logic                   grow_i,
  output logic [NUM_LANES-1:0]   lane_en_o,
  output logic [NUM_LANES-1:0]   quiesce_o,
  output logic [NUM_LANES-1:0]   train_req_o
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic cur_on, tgt_on;
    assign cur_on         = i < (1 << int'(cur_code_i));
    assign tgt_on         = i < (1 << int'(tgt_code_i));
    assign lane_en_o[i]   = cur_on;
    assign quiesce_o[i]   = shrink_i && cur_on && !tgt_on;
    assign train_req_o[i] = grow_i && tgt_on && !cur_on;
  end
endmodule

// File: rtl/lwn_ctrl.sv
module lwn_ctrl
  import lwn_pkg::*;
#(
  parameter int NUM_LANES   = 16,
  parameter int RESP_CYCLES = 1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dsp_i,
  input  logic                 loc_req_i,
  input  logic [2:0]           loc_width_i,
  output logic                 tx_req_o,
  output logic [2:0]           tx_width_o,
  output logic                 tx_ack_o,
  output logic                 tx_nak_o,
  input  logic                 rx_req_i,
  input  logic [2:0]           rx_width_i,
  input  logic                 rx_ack_i,
  input  logic                 rx_nak_i,
  output logic [NUM_LANES-1:0] quiesce_o,
  input  logic                 quiesce_done_i,
  output logic [NUM_LANES-1:0] train_req_o,
  input  logic                 train_done_i,
  output logic [NUM_LANES-1:0] lane_en_o,
  output logic [2:0]           cur_width_o,
  output logic                 done_o,
  output logic                 fail_o
);
  localparam int MAX_CODE = $clog2(NUM_LANES);

  lwn_state_e st_q;
  wcode_t     cur_q, tgt_q, hold_code;
  logic       hold_v, expire;
  logic       rx_ok, hold_ok, rx_take, consume, requeue, tmr_start;

  function automatic logic code_ok(wcode_t c, wcode_t cur);
    return (int'(c) <= MAX_CODE) && (c != cur);
  endfunction

  assign rx_ok     = code_ok(rx_width_i, cur_q);
  assign hold_ok   = code_ok(hold_code, cur_q);
  // upstream side with a queued request keeps priority in idle
  assign rx_take   = rx_req_i && !(hold_v && !dsp_i);
  assign consume   = (st_q == ST_IDLE) && hold_v && !rx_take;
  assign requeue   = (st_q == ST_WAIT) && !rx_ack_i && rx_req_i && dsp_i;
  assign tmr_start = consume && hold_ok;

  lwn_req_hold u_hold (
    .clk_i, .rst_ni,
    .load_i(loc_req_i), .load_code_i(loc_width_i),
    .consume_i(consume), .requeue_i(requeue), .requeue_code_i(tgt_q),
    .valid_o(hold_v), .code_o(hold_code)
  );

  lwn_resp_timer #(.RESP_CYCLES(RESP_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(tmr_start), .run_i(st_q == ST_WAIT), .expire_o(expire)
  );

  lwn_lane_map #(.NUM_LANES(NUM_LANES)) u_map (
    .cur_code_i(cur_q), .tgt_code_i(tgt_q),
    .shrink_i(st_q == ST_SHRINK), .grow_i(st_q == ST_GROW),
    .lane_en_o, .quiesce_o, .train_req_o
  );

  assign cur_width_o = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cur_q      <= wcode_t'(MAX_CODE);
      tgt_q      <= wcode_t'(MAX_CODE);
      tx_req_o   <= 1'b0;
      tx_width_o <= '0;
      tx_ack_o   <= 1'b0;
      tx_nak_o   <= 1'b0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
    end else begin
      tx_req_o <= 1'b0;
      tx_ack_o <= 1'b0;
      tx_nak_o <= 1'b0;
      done_o   <= 1'b0;
      fail_o   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (rx_take) begin
            if (rx_ok) begin
              tx_ack_o <= 1'b1;
              tgt_q    <= rx_width_i;
              st_q     <= (rx_width_i < cur_q) ? ST_SHRINK : ST_GROW;
            end else begin
              tx_nak_o <= 1'b1;
            end
          end else if (hold_v) begin
            if (rx_req_i) tx_nak_o <= 1'b1;
            if (hold_ok) begin
              tx_req_o   <= 1'b1;
              tx_width_o <= hold_code;
              tgt_q      <= hold_code;
              st_q       <= ST_WAIT;
            end else begin
              fail_o <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (rx_ack_i) begin
            if (rx_req_i) tx_nak_o <= 1'b1;
            st_q <= (tgt_q < cur_q) ? ST_SHRINK : ST_GROW;
          end else if (rx_req_i && dsp_i) begin
            // yield: own request goes back to the hold slot
            if (rx_ok) begin
              tx_ack_o <= 1'b1;
              tgt_q    <= rx_width_i;
              st_q     <= (rx_width_i < cur_q) ? ST_SHRINK : ST_GROW;
            end else begin
              tx_nak_o <= 1'b1;
              st_q     <= ST_IDLE;
            end
          end else begin
            if (rx_req_i) tx_nak_o <= 1'b1;
            if (rx_nak_i || expire) begin
              fail_o <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end
        end
        ST_SHRINK, ST_GROW: begin
          if (rx_req_i) tx_nak_o <= 1'b1;
          if ((st_q == ST_SHRINK) ? quiesce_done_i : train_done_i) begin
            cur_q  <= tgt_q;
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_tx_req_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o);

  assert_fail_keeps_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> $stable(cur_width_o));

  assert_ack_nak_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_ack_o, tx_nak_o}));

  assert_width_moves_on_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lane_en_o) |-> done_o);

  assert_shrink_holds_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|quiesce_o) && !quiesce_done_i) |=> $stable(lane_en_o));

  assert_grow_holds_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|train_req_o) && !train_done_i) |=> $stable(lane_en_o));

  assert_one_outstanding_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> !tx_req_o);

  assert_done_fail_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fail_o}));

  assert_lane_shape_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_en_o[0] && ($countones(lane_en_o) == (1 << int'(cur_width_o))));
endmodule

// File: tb/lwn_ctrl_bench.sv
module lwn_ctrl_bench;
  localparam int NL = 16;
  localparam int RC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dsp = 1'b0, loc_req = 1'b0, rx_req = 1'b0, rx_ack = 1'b0, rx_nak = 1'b0;
  logic q_done = 1'b0, t_done = 1'b0;
  logic [2:0] loc_w = '0, rx_w = '0;
  logic tx_req, tx_ack, tx_nak, done, fail;
  logic [2:0] tx_w, cur_w;
  logic [NL-1:0] quiesce, train, lane_en;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lwn_ctrl #(.NUM_LANES(NL), .RESP_CYCLES(RC)) u_lwn_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .dsp_i(dsp),
    .loc_req_i(loc_req), .loc_width_i(loc_w),
    .tx_req_o(tx_req), .tx_width_o(tx_w), .tx_ack_o(tx_ack), .tx_nak_o(tx_nak),
    .rx_req_i(rx_req), .rx_width_i(rx_w), .rx_ack_i(rx_ack), .rx_nak_i(rx_nak),
    .quiesce_o(quiesce), .quiesce_done_i(q_done),
    .train_req_o(train), .train_done_i(t_done),
    .lane_en_o(lane_en), .cur_width_o(cur_w), .done_o(done), .fail_o(fail)
  );

  // {partner code, expect accept, width code afterwards}, start at x16
  localparam logic [6:0] VEC [8] = '{
    {3'd4, 1'b0, 3'd4}, {3'd6, 1'b0, 3'd4}, {3'd2, 1'b1, 3'd2}, {3'd2, 1'b0, 3'd2},
    {3'd3, 1'b1, 3'd3}, {3'd0, 1'b1, 3'd0}, {3'd7, 1'b0, 3'd0}, {3'd4, 1'b1, 3'd4}
  };

  function automatic logic [NL-1:0] mask(input int code);
    logic [NL-1:0] m = '0;
    for (int i = 0; i < NL; i++) if (i < (2 ** code)) m[i] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic partner(input logic [2:0] w);
    rx_req = 1'b1; rx_w = w; step(); rx_req = 1'b0;
  endtask

  task automatic local_req(input logic [2:0] w);
    loc_req = 1'b1; loc_w = w; step(); loc_req = 1'b0;
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_sim();
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 lane_en", lane_en, mask(4));
    chk("R1 width", cur_w, 4);
    chk("R1 lane cmds", {quiesce, train}, 0);
    chk("R1 pulses", {tx_req, tx_ack, tx_nak, done, fail}, 0);

    // R4 R7 R8 R12 table of partner requests
    foreach (VEC[k]) begin
      logic [2:0] w, nw;
      logic acc;
      int old;
      {w, acc, nw} = VEC[k];
      old = int'(cur_w);
      partner(w);
      chk("R4 ack", tx_ack, acc);
      chk("R4 nak", tx_nak, !acc);
      if (acc) begin
        if (w < old) begin
          chk("R7 quiesce mask", quiesce, mask(old) & ~mask(w));
          chk("R7 lanes held", lane_en, mask(old));
          q_done = 1'b1; step(); q_done = 1'b0;
        end else begin
          chk("R8 train mask", train, mask(w) & ~mask(old));
          chk("R8 lanes held", lane_en, mask(old));
          t_done = 1'b1; step(); t_done = 1'b0;
        end
        chk("R7 R8 done", done, 1);
      end
      chk("R12 lane_en", lane_en, mask(nw));
      chk("R12 width", cur_w, nw);
    end

    // R2 issue timing, R6 reject
    local_req(3'd3);
    chk("R2 not yet", tx_req, 0);
    step();
    chk("R2 tx_req", tx_req, 1);
    chk("R2 tx_width", tx_w, 3);
    step();
    chk("R2 single pulse", tx_req, 0);
    rx_nak = 1'b1; step(); rx_nak = 1'b0;
    chk("R6 fail", fail, 1);
    chk("R6 width kept", cur_w, 4);

    // R3 unsupported and current width
    local_req(3'd5); step();
    chk("R3 no msg unsupported", tx_req, 0);
    chk("R3 fail unsupported", fail, 1);
    local_req(3'd4); step();
    chk("R3 no msg current", tx_req, 0);
    chk("R3 fail current", fail, 1);
    chk("R3 width kept", cur_w, 4);

    // R5 timeout
    local_req(3'd1); step();
    chk("R5 issued", tx_req, 1);
    for (int i = 0; i < RC - 1; i++) step();
    chk("R5 not early", fail, 0);
    step();
    chk("R5 timeout fail", fail, 1);
    chk("R5 width kept", cur_w, 4);

    // R5 answer on last allowed edge
    local_req(3'd3); step();
    for (int i = 0; i < RC - 1; i++) step();
    rx_ack = 1'b1; step(); rx_ack = 1'b0;
    chk("R5 last edge no fail", fail, 0);
    chk("R5 last edge quiesce", quiesce, 16'hff00);
    q_done = 1'b1; step(); q_done = 1'b0;
    chk("R7 lanes after quiesce", lane_en, 16'h00ff);

    // R9 collision on holding side
    dsp = 1'b0;
    local_req(3'd4); step();
    chk("R9 issued", tx_req, 1);
    partner(3'd1);
    chk("R9 nak partner", tx_nak, 1);
    chk("R9 no ack", tx_ack, 0);
    rx_ack = 1'b1; step(); rx_ack = 1'b0;
    chk("R9 R8 train", train, 16'hff00);
    chk("R8 lanes held", lane_en, 16'h00ff);
    t_done = 1'b1; step(); t_done = 1'b0;
    chk("R8 lanes after train", lane_en, 16'hffff);

    // R11 busy: held local request, partner rejected
    partner(3'd2);
    chk("R11 accept", tx_ack, 1);
    local_req(3'd4);
    chk("R11 held not sent", tx_req, 0);
    partner(3'd3);
    chk("R11 nak in transition", tx_nak, 1);
    q_done = 1'b1; step(); q_done = 1'b0;
    chk("R11 width x4", lane_en, 16'h000f);
    step();
    chk("R11 held issued", tx_req, 1);
    chk("R11 held width", tx_w, 4);
    rx_nak = 1'b1; step(); rx_nak = 1'b0;
    chk("R11 reject fail", fail, 1);

    // R10 collision on yielding side
    dsp = 1'b1;
    local_req(3'd4); step();
    chk("R10 issued", tx_req, 1);
    partner(3'd0);
    chk("R10 ack partner", tx_ack, 1);
    chk("R10 no fail", fail, 0);
    chk("R10 quiesce", quiesce, 16'h000e);
    q_done = 1'b1; step(); q_done = 1'b0;
    chk("R10 lanes x1", lane_en, 16'h0001);
    step();
    chk("R10 reissue", tx_req, 1);
    chk("R10 reissue width", tx_w, 4);
    rx_ack = 1'b1; step(); rx_ack = 1'b0;
    chk("R10 train", train, 16'hfffe);
    t_done = 1'b1; step(); t_done = 1'b0;
    chk("R10 lanes x16", lane_en, 16'hffff);

    finish_sim();
  end
endmodule